// File: doc/BRIEF.md
# SPI register-access frame decoder

This block is an SPI slave for clock mode 0 (SCLK idles low, data sampled on the rising edge, changed on the falling edge) that turns serial register-access frames into byte-wide accesses on a parallel register port. Each frame starts when chip select goes low. It carries a 16-bit register address, then a control byte, then a data phase. SCLK, chip select and MOSI are brought into the system clock domain through a short synchronizer. Every SCLK half period must therefore last at least six system clocks.

The control byte gives three things: a target block (a socket number and a part within that socket), a transfer direction, and a length mode. The length mode picks one of two endings. In variable mode the data phase runs until chip select is released. In fixed mode it ends after a set number of bytes. On a write, each completed data byte is presented on the write port with its address and block. On a read, the decoder fetches a byte from the read port before the byte's first bit is needed and shifts it out on MISO. The address steps by one after every data byte. Raising chip select at any moment abandons the frame, and the next frame starts again with the address.

Top module: `spi_regframe_decoder`

## Requirements
- R1: The first two bytes after chip select falls form the 16-bit register address, with the most significant byte first. All bytes on the wire are sent most significant bit first.
- R2: The third byte is the control byte. Bits 7:5 are a socket number, presented on `blkSocket`. Bits 4:3 are the part, presented on `blkPart` (00 common registers, 01 socket registers, 10 transmit buffer, 11 receive buffer). Bit 2 is the direction (1 write, 0 read). Bits 1:0 are the length mode.
- R3: In a write frame, each completed data byte produces exactly one single-cycle `wrStb` pulse. During that pulse `wrData` holds the byte, and `regAddr`, `blkSocket` and `blkPart` hold its target.
- R4: In a read frame, a single-cycle `rdStb` pulse samples `rdData` for the current `regAddr` in the same cycle. That byte appears on MISO most significant bit first. Its first bit is valid before the first rising SCLK edge of the byte, and each following bit changes on a falling edge.
- R5: `regAddr` increases by one (modulo 2^16) after each data-byte access in either direction. The first data byte uses the address from the header.
- R6: Length mode 00 is variable: data bytes keep being accepted until chip select rises.
- R7: Length modes 01, 10 and 11 allow 1, 2 and 4 data bytes. Bytes clocked after that count produce no strobes, and MISO reads as 0 for them, until chip select rises.
- R8: MISO is held at 0 during the address and control bytes and during the write data phase.
- R9: During the read data phase, MOSI is ignored and no `wrStb` is produced.
- R10: If chip select rises part-way through a byte, that byte is not committed. The next frame starts with the address phase.
- R11: After reset, `spiMiso`, `wrStb` and `rdStb` are 0 and `regAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Serial clock from the master, mode 0 |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from the master |
| spiMiso | output | 1 | Serial data to the master |
| regAddr | output | 16 | Address of the current data byte |
| blkSocket | output | 3 | Socket number from the control byte |
| blkPart | output | 2 | Part select from the control byte |
| wrStb | output | 1 | One-cycle write strobe per committed byte |
| wrData | output | 8 | Byte being written |
| rdStb | output | 1 | One-cycle read fetch strobe |
| rdData | input | 8 | Byte returned for `regAddr` while `rdStb` is high |

## Verification
The bench sends fixed-length frames with more bytes than their count allows. A decoder that miscounted the 1, 2 or 4 limit would emit extra write strobes, or would keep driving read bytes instead of zeros. One variable-length write starts at address 0xFFFE, so an address counter that did not wrap would send bytes to the wrong place. Chip select is also raised part-way through a data byte and part-way through the address. A decoder that committed partial bytes, or did not return to the address phase, would emit a spurious strobe or decode the next frame at the wrong address. Read frames carry random MOSI traffic, and every MISO bit is captured during headers and writes. This exposes a late first-bit prefetch, a shift that happens one edge too early, a write leaking out of a read, and MISO that is not held quiet.

// File: rtl/spiframe_pkg.sv
`timescale 1ns/1ps
package spiframe_pkg;

  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 16;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam int LEN_CNT_W = 3;

  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  // control byte field positions (decoded by the register side)
  localparam int CB_DIR_BIT = 2;
  localparam int CB_LEN_HI  = 1;
  localparam int CB_PART_LO = 3;
  localparam int CB_SOCK_LO = 5;

  typedef enum logic [2:0] {
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_CTRL,
    PH_DATA,
    PH_DRAIN
  } phase_e;

  typedef struct packed {
    logic ldAddrHi;
    logic ldAddrLo;
    logic ldCtrl;
    logic wrByte;
    logic fetch;
    logic shiftTx;
    logic misoEn;
  } ctl_strobe_t;

  // byte budget of a length mode; 0 means open-ended
  function automatic logic [LEN_CNT_W-1:0] lenLimit(input logic [1:0] mode);
    case (mode)
      2'b01:   return LEN_CNT_W'(1);
      2'b10:   return LEN_CNT_W'(2);
      2'b11:   return LEN_CNT_W'(4);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/spiframe_dp.sv
`timescale 1ns/1ps
module spiframe_dp
  import spiframe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkIn,
  input  logic                 csNIn,
  input  logic                 mosiIn,
  input  ctl_strobe_t          stb,
  output logic                 sclkRise,
  output logic                 sclkFall,
  output logic                 csActive,
  output logic [BYTE_W-1:0]    rxFull,
  output logic                 ctrlWrite,
  output logic [1:0]           ctrlLen,
  output logic [ADDR_W-1:0]    regAddr,
  output logic [2:0]           blkSocket,
  output logic [1:0]           blkPart,
  output logic                 wrStb,
  output logic [BYTE_W-1:0]    wrData,
  output logic                 rdStb,
  input  logic [BYTE_W-1:0]    rdData,
  output logic                 miso
);

  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic                   sclkPrev;
  logic                   sclkS, mosiS;
  logic [BYTE_W-1:0]      rxShift;
  logic [BYTE_W-1:0]      txShift;
  logic [BYTE_W-1:0]      ctrlByte;

  // synchronizer chains, SYNC_STAGES deep
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          csPipe   <= '1;
          mosiPipe <= '0;
        end else begin
          sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
          csPipe   <= {csPipe[SYNC_STAGES-2:0], csNIn};
          mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          csPipe   <= '1;
          mosiPipe <= '0;
        end else begin
          sclkPipe <= sclkIn;
          csPipe   <= csNIn;
          mosiPipe <= mosiIn;
        end
      end
    end
  endgenerate

  assign sclkS    = sclkPipe[SYNC_TOP];
  assign mosiS    = mosiPipe[SYNC_TOP];
  assign csActive = ~csPipe[SYNC_TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  assign sclkRise = csActive &  sclkS & ~sclkPrev;
  assign sclkFall = csActive & ~sclkS &  sclkPrev;
  assign rxFull   = {rxShift[BYTE_W-2:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rxShift <= '0;
    else if (sclkRise) rxShift <= rxFull;
  end

  // address register: loaded from header, stepped after each access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr <= '0;
    end else if (stb.ldAddrHi) begin
      regAddr[ADDR_W-1:BYTE_W] <= rxFull;
    end else if (stb.ldAddrLo) begin
      regAddr[BYTE_W-1:0] <= rxFull;
    end else if (wrStb || rdStb) begin
      regAddr <= regAddr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctrlByte <= '0;
    else if (stb.ldCtrl) ctrlByte <= rxFull;
  end

  assign ctrlWrite = ctrlByte[CB_DIR_BIT];
  assign ctrlLen   = ctrlByte[CB_LEN_HI -: 2];
  assign blkSocket = ctrlByte[CB_SOCK_LO +: 3];
  assign blkPart   = ctrlByte[CB_PART_LO +: 2];

  // write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStb  <= 1'b0;
      wrData <= '0;
    end else begin
      wrStb <= stb.wrByte;
      if (stb.wrByte) wrData <= rxFull;
    end
  end

  // read port and transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdStb   <= 1'b0;
      txShift <= '0;
    end else begin
      rdStb <= stb.fetch;
      if (rdStb)            txShift <= rdData;
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = stb.misoEn & txShift[BYTE_W-1];

  // R3
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

  // R3
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb && rdStb));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb || rdStb) |=> regAddr == $past(regAddr) + ADDR_W'(1));

  // R10
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !(stb.wrByte || stb.fetch || stb.ldAddrHi || stb.ldCtrl));

endmodule

// File: rtl/spiframe_ctrl.sv
`timescale 1ns/1ps
module spiframe_ctrl
  import spiframe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              csActive,
  input  logic [BYTE_W-1:0] rxFull,
  input  logic              ctrlWrite,
  input  logic [1:0]        ctrlLen,
  output ctl_strobe_t       stb
);

  phase_e                 phase;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic [LEN_CNT_W-1:0]   dataCnt;
  logic [LEN_CNT_W-1:0]   limit;
  logic                   fixedLen;
  logic                   lastFixed;
  logic                   byteDone;

  assign limit     = lenLimit(ctrlLen);
  assign fixedLen  = (ctrlLen != 2'b00);
  assign lastFixed = fixedLen && (dataCnt + LEN_CNT_W'(1) == limit);
  assign byteDone  = sclkRise && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_ADDR_HI;
      bitCnt  <= '0;
      dataCnt <= '0;
    end else if (!csActive) begin
      phase   <= PH_ADDR_HI;
      bitCnt  <= '0;
      dataCnt <= '0;
    end else if (sclkRise) begin
      bitCnt <= bitCnt + BIT_CNT_W'(1);
      if (bitCnt == LAST_BIT) begin
        case (phase)
          PH_ADDR_HI: phase <= PH_ADDR_LO;
          PH_ADDR_LO: phase <= PH_CTRL;
          PH_CTRL:    phase <= PH_DATA;
          PH_DATA: begin
            if (fixedLen) begin
              dataCnt <= dataCnt + LEN_CNT_W'(1);
              if (lastFixed) phase <= PH_DRAIN;
            end
          end
          default:    phase <= PH_DRAIN;
        endcase
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.ldAddrHi = byteDone && (phase == PH_ADDR_HI);
    stb.ldAddrLo = byteDone && (phase == PH_ADDR_LO);
    stb.ldCtrl   = byteDone && (phase == PH_CTRL);
    stb.wrByte   = byteDone && (phase == PH_DATA) && ctrlWrite;
    stb.fetch    = byteDone &&
                   (((phase == PH_CTRL) && !rxFull[CB_DIR_BIT]) ||
                    ((phase == PH_DATA) && !ctrlWrite && !lastFixed));
    stb.shiftTx  = sclkFall && (phase == PH_DATA) && !ctrlWrite &&
                   (bitCnt != '0);
    stb.misoEn   = (phase == PH_DATA) && !ctrlWrite;
  end

  // R7
  len_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_DATA) && fixedLen) |-> (dataCnt < limit));

  // R9
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrByte && stb.fetch));

  // R10
  cs_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (phase == PH_ADDR_HI) && (bitCnt == '0));

endmodule

// File: rtl/spi_regframe_decoder.sv
`timescale 1ns/1ps
module spi_regframe_decoder
  import spiframe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiSclk,
  input  logic        spiCsN,
  input  logic        spiMosi,
  output logic        spiMiso,
  output logic [15:0] regAddr,
  output logic [2:0]  blkSocket,
  output logic [1:0]  blkPart,
  output logic        wrStb,
  output logic [7:0]  wrData,
  output logic        rdStb,
  input  logic [7:0]  rdData
);

  ctl_strobe_t       stb;
  logic              sclkRise, sclkFall, csActive;
  logic [BYTE_W-1:0] rxFull;
  logic              ctrlWrite;
  logic [1:0]        ctrlLen;

  spiframe_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclkIn    (spiSclk),
    .csNIn     (spiCsN),
    .mosiIn    (spiMosi),
    .stb       (stb),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall),
    .csActive  (csActive),
    .rxFull    (rxFull),
    .ctrlWrite (ctrlWrite),
    .ctrlLen   (ctrlLen),
    .regAddr   (regAddr),
    .blkSocket (blkSocket),
    .blkPart   (blkPart),
    .wrStb     (wrStb),
    .wrData    (wrData),
    .rdStb     (rdStb),
    .rdData    (rdData),
    .miso      (spiMiso)
  );

  spiframe_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall),
    .csActive  (csActive),
    .rxFull    (rxFull),
    .ctrlWrite (ctrlWrite),
    .ctrlLen   (ctrlLen),
    .stb       (stb)
  );

endmodule

// File: tb/spi_regframe_decoder_tb.sv
`timescale 1ns/1ps
module spi_regframe_decoder_tb_top;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiSclk = 1'b0;
  logic        spiCsN = 1'b1;
  logic        spiMosi = 1'b0;
  logic        spiMiso;
  logic [15:0] regAddr;
  logic [2:0]  blkSocket;
  logic [1:0]  blkPart;
  logic        wrStb;
  logic [7:0]  wrData;
  logic        rdStb;
  logic [7:0]  rdData;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] memVal(input logic [15:0] a, input logic [4:0] blk);
    return {a[6:0], a[7]} ^ a[15:8] ^ {blk, 3'b011};
  endfunction

  assign rdData = memVal(regAddr, {blkSocket, blkPart});

  spi_regframe_decoder dut_i (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .regAddr(regAddr),
    .blkSocket(blkSocket), .blkPart(blkPart), .wrStb(wrStb),
    .wrData(wrData), .rdStb(rdStb), .rdData(rdData)
  );

  // write port monitor
  int          wCnt = 0;
  logic [15:0] wAddr [0:1023];
  logic [7:0]  wDat  [0:1023];
  logic [4:0]  wBlk  [0:1023];

  always @(posedge clk) begin
    if (wrStb && wCnt < 1024) begin
      wAddr[wCnt] = regAddr;
      wDat[wCnt]  = wrData;
      wBlk[wCnt]  = {blkSocket, blkPart};
    end
    if (wrStb) wCnt = wCnt + 1;
  end

  logic [7:0] txBuf [0:15];
  logic [7:0] rxBuf [0:15];
  logic [7:0] hdrRx [0:2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      spiMosi = tx[i];
      waitClk(HALF);
      rx[i] = spiMiso;
      spiSclk = 1'b1;
      waitClk(HALF);
      spiSclk = 1'b0;
    end
  endtask

  task automatic runFrame(input logic [15:0] a, input logic [7:0] ctl, input int n,
                          input int partialBits, output int base);
    logic [7:0] junk;
    base = wCnt;
    spiCsN = 1'b0;
    waitClk(HALF);
    xferBits(a[15:8], 8, hdrRx[0]);
    xferBits(a[7:0], 8, hdrRx[1]);
    xferBits(ctl, 8, hdrRx[2]);
    for (int i = 0; i < n; i++) xferBits(txBuf[i], 8, rxBuf[i]);
    if (partialBits > 0) xferBits(txBuf[n], partialBits, junk);
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(4 * HALF);
  endtask

  task automatic checkFrame(input logic [15:0] a, input logic [7:0] ctl, input int n, input int base);
    int lim, eff, got;
    logic [7:0] exp;
    lim = (ctl[1:0] == 2'b00) ? 0 : (1 << (ctl[1:0] - 1));
    eff = (lim == 0) ? n : ((n < lim) ? n : lim);
    got = wCnt - base;
    for (int h = 0; h < 3; h++)
      chk(hdrRx[h] == 8'h00, "R8 miso quiet in header", hdrRx[h], 0);
    if (ctl[2]) begin
      chk(got == eff, "R3 R6 R7 R10 write strobe count", got, eff);
      for (int i = 0; i < eff && i < got; i++) begin
        chk(wAddr[base+i] == 16'(a + i), "R1 R5 write address", wAddr[base+i], 16'(a + i));
        chk(wDat[base+i] == txBuf[i], "R3 write data", wDat[base+i], txBuf[i]);
        chk(wBlk[base+i] == ctl[7:3], "R2 block select", wBlk[base+i], ctl[7:3]);
      end
      for (int i = 0; i < n; i++)
        chk(rxBuf[i] == 8'h00, "R8 miso quiet in write", rxBuf[i], 0);
    end else begin
      chk(got == 0, "R9 no write during read", got, 0);
      for (int i = 0; i < n; i++) begin
        exp = (i < eff) ? memVal(16'(a + i), ctl[7:3]) : 8'h00;
        chk(rxBuf[i] == exp, "R4 R5 R6 R7 read byte on miso", rxBuf[i], exp);
      end
    end
  endtask

  task automatic fillTx();
    for (int i = 0; i < 16; i++) txBuf[i] = 8'($urandom);
  endtask

  task automatic doFrame(input logic [15:0] a, input logic [7:0] ctl, input int n, input int partialBits);
    int base;
    fillTx();
    runFrame(a, ctl, n, partialBits, base);
    checkFrame(a, ctl, n, base);
  endtask

  initial begin
    int base;
    logic [7:0] junk;
    void'($urandom(32'd20240611));
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R11 reset state
    chk(spiMiso == 1'b0, "R11 miso after reset", spiMiso, 0);
    chk(wrStb == 1'b0, "R11 wrStb after reset", wrStb, 0);
    chk(rdStb == 1'b0, "R11 rdStb after reset", rdStb, 0);
    chk(regAddr == 16'h0, "R11 address after reset", regAddr, 0);

    // R7 fixed writes with surplus bytes
    doFrame(16'h1234, {3'd2, 2'b01, 1'b1, 2'b01}, 3, 0);
    doFrame(16'h0400, {3'd5, 2'b10, 1'b1, 2'b10}, 2, 0);
    doFrame(16'h8001, {3'd7, 2'b11, 1'b1, 2'b11}, 6, 0);
    // R6 R5 variable write across address wrap
    doFrame(16'hFFFE, {3'd0, 2'b00, 1'b1, 2'b00}, 5, 0);
    // R7 R4 fixed reads with surplus bytes, R9 random MOSI
    doFrame(16'h0A0B, {3'd3, 2'b11, 1'b0, 2'b11}, 6, 0);
    doFrame(16'h7F00, {3'd1, 2'b01, 1'b0, 2'b01}, 2, 0);
    doFrame(16'h00FF, {3'd6, 2'b10, 1'b0, 2'b10}, 3, 0);
    // R6 variable read
    doFrame(16'hFFFF, {3'd4, 2'b01, 1'b0, 2'b00}, 4, 0);
    // R10 abort inside a data byte
    doFrame(16'h2222, {3'd2, 2'b10, 1'b1, 2'b00}, 2, 5);
    // R10 abort inside the address, then a clean frame
    base = wCnt;
    spiCsN = 1'b0;
    waitClk(HALF);
    xferBits(8'hC3, 8, junk);
    xferBits(8'h5A, 3, junk);
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(4 * HALF);
    chk(wCnt == base, "R10 no write after header abort", wCnt - base, 0);
    doFrame(16'h3344, {3'd1, 2'b11, 1'b1, 2'b01}, 1, 0);

    // random frames
    for (int f = 0; f < 30; f++) begin
      logic [15:0] a;
      logic [7:0]  ctl;
      int n;
      a   = 16'($urandom);
      ctl = 8'($urandom);
      n   = 1 + int'($urandom % 6);
      doFrame(a, ctl, n, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule